// File: doc/BRIEF.md
# Address-Latching Parallel Byte Memory

This block is a clocked, synthesizable model of a nonvolatile byte-wide memory that sits behind an asynchronous parallel bus with three active-low strobes: chip enable, write enable and output enable. A fast system clock samples all bus inputs. Each input passes through a two-flop synchronizer before any edge is detected.

A falling chip enable starts a memory cycle and captures the address once. From that point the cycle runs for a fixed access time counted in clock ticks, even if chip enable returns high early. A cycle that starts with write enable already low is a write, and the block never drives the bus during it. A cycle that starts with write enable high is a read. It drives data only after the access time, and only while output enable is low. It can turn into a write when write enable falls later. A write stores the data present when the first of write enable or chip enable rises.

Between cycles, chip enable must stay high for a minimum precharge time. A start that arrives too early, or while the previous cycle is still running, is ignored and raises a sticky error flag. The data bus is split into an input, an output and an output enable. `ADDR_W` = 15 gives the full 32K x 8 array. The default is kept smaller. The top five address bits name an internal segment, and the segment has no effect on behaviour.

Top module: `latched_byte_mem`

## Requirements
- R1: The array holds 2**ADDR_W bytes. A byte written at an address reads back unchanged. Addresses that differ only in their top five bits (the segment field) are independent locations.
- R2: The address is captured when the synchronized chip enable falls. Changes to `bus_addr` after that point do not affect the cycle.
- R3: A read cycle keeps `bus_dout_en` low until the access time has passed. Suppose `bus_ce_n` and `bus_oe_n` go low together. Counting the first rising clock edge after that change as edge 1, `bus_dout_en` is still 0 after edge ACC_CYC+2 and is 1 after edge ACC_CYC+3. `bus_dout` then carries the stored byte.
- R4: While `bus_oe_n` is high (1), `bus_dout_en` stays 0.
- R5: A cycle that starts with `bus_we_n` = 0 is a write. It never raises `bus_dout_en`, and it stores `bus_din` at the first rise of `bus_we_n` or `bus_ce_n`.
- R6: A read cycle in which `bus_we_n` falls stops driving the bus and becomes a write. It stores `bus_din` at the first rise of `bus_we_n` or `bus_ce_n`.
- R7: A started cycle lasts at least ACC_CYC clocks, even if `bus_ce_n` rises early. A chip enable fall during that time is ignored and sets `cycle_err` to 1.
- R8: A chip enable fall that follows fewer than PRE_CYC synchronized high clocks of `bus_ce_n` is ignored and sets `cycle_err`. `cycle_err` stays 1 until reset.
- R9: After synchronous reset, `bus_dout_en` = 0 and `cycle_err` = 0. Reset does not clear the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_ce_n | input | 1 | Chip enable, active low, asynchronous |
| bus_we_n | input | 1 | Write enable, active low, asynchronous |
| bus_oe_n | input | 1 | Output enable, active low, asynchronous |
| bus_addr | input | ADDR_W | Byte address |
| bus_din | input | DATA_W | Write data from the bus |
| bus_dout | output | DATA_W | Read data toward the bus |
| bus_dout_en | output | 1 | Drive enable for bus_dout (0 = tri-state) |
| cycle_err | output | 1 | Sticky flag: a cycle start was rejected |

## Verification
The bench samples the drive enable on the exact clock edges on either side of the access time. A design that drops a synchronizer stage, or counts one tick too few or too many, fails that check. It changes the address shortly after a cycle starts. A design that tracks the live address then returns the wrong byte. It also performs writes ended by chip enable as well as by write enable, and writes that turn from a read part-way through. A design that commits at the wrong edge, or keeps driving after write enable falls, shows stale data or an extra drive. Finally, it starts a cycle while the previous one is still counting, and again after too short a precharge. A design that accepts either start overwrites a byte the bench expects to keep, and leaves the error flag clear.

// File: rtl/lbm_pkg.sv
package lbm_pkg;

    typedef enum logic [1:0] {
        KIND_NONE  = 2'd0,
        KIND_READ  = 2'd1,
        KIND_WRITE = 2'd2
    } cyc_kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
    } bus_ctl_t;

    typedef struct packed {
        logic start;
        logic ce_rise;
        logic we_fall;
        logic we_rise;
    } bus_evt_t;

    localparam int CTL_W = $bits(bus_ctl_t);
    localparam int SEG_BITS = 5;

    function automatic int cnt_width(int a, int b);
        int m;
        m = (a > b) ? a : b;
        return (m < 1) ? 1 : $clog2(m + 1);
    endfunction

    function automatic bus_evt_t detect_edges(bus_ctl_t prev, bus_ctl_t cur);
        bus_evt_t e;
        e.start   = prev.ce_n & ~cur.ce_n;
        e.ce_rise = ~prev.ce_n & cur.ce_n;
        e.we_fall = prev.we_n & ~cur.we_n;
        e.we_rise = ~prev.we_n & cur.we_n;
        return e;
    endfunction

endpackage

// File: rtl/lbm_sync.sv
module lbm_sync
    import lbm_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ctl_t          ctl_raw,
    input  logic [ADDR_W-1:0] addr_raw,
    input  logic [DATA_W-1:0] data_raw,
    output bus_ctl_t          ctl_s,
    output logic [ADDR_W-1:0] addr_s,
    output logic [DATA_W-1:0] data_s,
    output bus_evt_t          evt
);

    localparam int PW = CTL_W + ADDR_W + DATA_W;
    localparam logic [PW-1:0] RST_VAL = {{CTL_W{1'b1}}, {(ADDR_W + DATA_W){1'b0}}};

    logic [PW-1:0] stg [SYNC_STAGES];
    bus_ctl_t      prev_ctl;

    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= RST_VAL;
                else     stg[i] <= {ctl_raw, addr_raw, data_raw};
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= RST_VAL;
                else     stg[i] <= stg[i-1];
            end
        end
    end

    assign ctl_s  = bus_ctl_t'(stg[SYNC_STAGES-1][PW-1 -: CTL_W]);
    assign addr_s = stg[SYNC_STAGES-1][DATA_W +: ADDR_W];
    assign data_s = stg[SYNC_STAGES-1][DATA_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) prev_ctl <= '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1};
        else     prev_ctl <= ctl_s;
    end

    assign evt = detect_edges(prev_ctl, ctl_s);

endmodule

// File: rtl/lbm_seq.sv
module lbm_seq
    import lbm_pkg::*;
#(
    parameter int ADDR_W  = 11,
    parameter int ACC_CYC = 4,
    parameter int PRE_CYC = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ctl_t          ctl_s,
    input  bus_evt_t          evt,
    input  logic [ADDR_W-1:0] addr_s,
    output logic [ADDR_W-1:0] addr_lat,
    output logic              wr_en,
    output logic              data_oe,
    output logic              start_err
);

    localparam int CW = cnt_width(ACC_CYC, PRE_CYC);
    localparam logic [CW-1:0] ACC_L = CW'(ACC_CYC);
    localparam logic [CW-1:0] PRE_L = CW'(PRE_CYC);

    seq_state_e    state;
    cyc_kind_e     kind;
    logic          ce_open;
    logic          wr_done;
    logic [CW-1:0] acc_cnt;
    logic [CW-1:0] pre_cnt;

    logic acc_done, pre_ok, accept, reject;

    assign acc_done = (acc_cnt == ACC_L);
    assign pre_ok   = (pre_cnt >= PRE_L);
    assign accept   = evt.start && (state == ST_IDLE) && pre_ok;
    assign reject   = evt.start && !accept;

    assign wr_en = (state == ST_BUSY) && (kind == KIND_WRITE) && ce_open && !wr_done
                   && (evt.we_rise || evt.ce_rise);

    assign data_oe = (state == ST_BUSY) && (kind == KIND_READ) && ce_open && acc_done
                     && !ctl_s.oe_n && ctl_s.we_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            kind      <= KIND_NONE;
            ce_open   <= 1'b0;
            wr_done   <= 1'b0;
            acc_cnt   <= '0;
            pre_cnt   <= PRE_L;
            addr_lat  <= '0;
            start_err <= 1'b0;
        end else begin
            if (ctl_s.ce_n) pre_cnt <= pre_ok ? pre_cnt : pre_cnt + 1'b1;
            else            pre_cnt <= '0;

            if (reject) start_err <= 1'b1;

            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state    <= ST_BUSY;
                        addr_lat <= addr_s;
                        kind     <= ctl_s.we_n ? KIND_READ : KIND_WRITE;
                        ce_open  <= 1'b1;
                        wr_done  <= 1'b0;
                        acc_cnt  <= '0;
                    end
                end
                ST_BUSY: begin
                    if (!acc_done)   acc_cnt <= acc_cnt + 1'b1;
                    if (evt.ce_rise) ce_open <= 1'b0;
                    if (kind == KIND_READ && ce_open && evt.we_fall) kind <= KIND_WRITE;
                    if (wr_en)       wr_done <= 1'b1;
                    if (acc_done && !ce_open) begin
                        state <= ST_IDLE;
                        kind  <= KIND_NONE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2: the latched address holds for the whole cycle
    a_r2_addr_hold: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BUSY && $past(state == ST_BUSY)) |-> $stable(addr_lat));

    // R7: a cycle cannot end before its access count completes
    a_r7_full_cycle: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BUSY && !acc_done) |=> (state == ST_BUSY));

    // R8: a cycle only begins after a satisfied precharge
    a_r8_pre_gate: assert property (@(posedge clk) disable iff (rst)
        $rose(state == ST_BUSY) |-> $past(pre_ok));

    // R8: the error flag is sticky
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
        start_err |=> start_err);

    // R5: at most one commit per cycle
    a_r5_one_commit: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

endmodule

// File: rtl/lbm_array.sv
module lbm_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/latched_byte_mem.sv
module latched_byte_mem
    import lbm_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int DATA_W      = 8,
    parameter int ACC_CYC     = 4,
    parameter int PRE_CYC     = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_ce_n,
    input  logic              bus_we_n,
    input  logic              bus_oe_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_din,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_dout_en,
    output logic              cycle_err
);

    bus_ctl_t          ctl_raw, ctl_s;
    bus_evt_t          evt;
    logic [ADDR_W-1:0] addr_s, addr_lat;
    logic [DATA_W-1:0] data_s;
    logic              wr_en;

    assign ctl_raw = '{ce_n: bus_ce_n, we_n: bus_we_n, oe_n: bus_oe_n};

    lbm_sync #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk(clk), .rst(rst), .ctl_raw(ctl_raw), .addr_raw(bus_addr),
        .data_raw(bus_din), .ctl_s(ctl_s), .addr_s(addr_s),
        .data_s(data_s), .evt(evt)
    );

    lbm_seq #(
        .ADDR_W(ADDR_W), .ACC_CYC(ACC_CYC), .PRE_CYC(PRE_CYC)
    ) u_seq (
        .clk(clk), .rst(rst), .ctl_s(ctl_s), .evt(evt), .addr_s(addr_s),
        .addr_lat(addr_lat), .wr_en(wr_en), .data_oe(bus_dout_en),
        .start_err(cycle_err)
    );

    lbm_array #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_array (
        .clk(clk), .wr_en(wr_en), .wr_addr(addr_lat), .wr_data(data_s),
        .rd_addr(addr_lat), .rd_data(bus_dout)
    );

    // R4: the bus is driven only while the sampled output enable is low
    a_r4_oe_gate: assert property (@(posedge clk) disable iff (rst)
        bus_dout_en |-> !ctl_s.oe_n);

    // R6: driving stops as soon as the sampled write enable is low
    a_r6_we_quiet: assert property (@(posedge clk) disable iff (rst)
        bus_dout_en |-> ctl_s.we_n);

    // R5: a commit never coincides with a drive
    a_r5_no_drive_on_write: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !bus_dout_en);

endmodule

// File: tb/sim_latched_byte_mem.sv
module sim_latched_byte_mem;

    localparam int AW  = 11;
    localparam int DW  = 8;
    localparam int ACC = 8;
    localparam int PRE = 3;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst = 1'b1;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          den, err;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [DW-1:0] exp_q [$];
    string         tag_q [$];

    latched_byte_mem #(
        .ADDR_W(AW), .DATA_W(DW), .ACC_CYC(ACC), .PRE_CYC(PRE), .SYNC_STAGES(2)
    ) u0 (
        .clk(clk), .rst(rst), .bus_ce_n(ce_n), .bus_we_n(we_n), .bus_oe_n(oe_n),
        .bus_addr(addr), .bus_din(din), .bus_dout(dout), .bus_dout_en(den),
        .cycle_err(err)
    );

    task automatic check(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: each new drive of the bus pops one expected byte.
    logic prev_en = 1'b0;
    always @(negedge clk) begin : mon
        logic [DW-1:0] e;
        string t;
        if (!rst && den && !prev_en) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 unexpected drive", int'(dout), 0);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(dout == e, t, int'(dout), int'(e));
            end
        end
        prev_en = den;
    end

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_idle(int n);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        wait_n(n);
    endtask

    task automatic read_at(logic [AW-1:0] a, logic [DW-1:0] e, string tag,
                           bit swap, logic [AW-1:0] swap_a);
        addr = a; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        wait_n(3);
        if (swap) addr = swap_a;
        wait_n(ACC - 1);
        check(den == 1'b0, "R3 drive before access time", int'(den), 0);
        wait_n(1);
        check(den == 1'b1, "R3 drive after access time", int'(den), 1);
        wait_n(2);
        bus_idle(PRE + 8);
    endtask

    task automatic write_ce(logic [AW-1:0] a, logic [DW-1:0] d);
        bit seen;
        seen = 1'b0;
        addr = a; din = d; we_n = 1'b0; ce_n = 1'b0; oe_n = 1'b0;
        for (int i = 0; i < ACC + 4; i++) begin
            wait_n(1);
            if (den) seen = 1'b1;
        end
        check(!seen, "R5 write cycle drove bus", int'(seen), 0);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        wait_n(PRE + 8);
    endtask

    initial begin
        wait_n(4);
        rst = 1'b0;
        wait_n(2);
        check(den == 1'b0, "R9 reset drive enable", int'(den), 0);
        check(err == 1'b0, "R9 reset error flag", int'(err), 0);

        // R1: segment field does not alias locations
        write_ce(11'h005, 8'hA5);
        write_ce(11'h405, 8'h5B);
        write_ce(11'h7C5, 8'hC3);
        read_at(11'h005, 8'hA5, "R1 segment 0 readback", 1'b0, '0);
        read_at(11'h405, 8'h5B, "R1 segment 16 readback", 1'b0, '0);
        read_at(11'h7C5, 8'hC3, "R1 segment 31 readback", 1'b0, '0);

        // R2: address change after the start is ignored
        read_at(11'h005, 8'hA5, "R2 latched address", 1'b1, 11'h405);

        // R4: output enable held high, no drive
        begin
            bit seen;
            seen = 1'b0;
            addr = 11'h005; we_n = 1'b1; oe_n = 1'b1; ce_n = 1'b0;
            for (int i = 0; i < ACC + 6; i++) begin
                wait_n(1);
                if (den) seen = 1'b1;
            end
            check(!seen, "R4 drive with output enable high", int'(seen), 0);
            bus_idle(PRE + 8);
        end

        // R6: read turned into write, ended by write enable rising
        write_ce(11'h123, 8'h11);
        addr = 11'h123; we_n = 1'b1; oe_n = 1'b0; ce_n = 1'b0;
        exp_q.push_back(8'h11);
        tag_q.push_back("R6 read phase data");
        wait_n(ACC + 4);
        check(den == 1'b1, "R6 read phase drive", int'(den), 1);
        we_n = 1'b0;
        wait_n(3);
        check(den == 1'b0, "R6 drive stops at write enable", int'(den), 0);
        din = 8'h3C;
        wait_n(2);
        we_n = 1'b1;
        wait_n(3);
        bus_idle(PRE + 8);
        read_at(11'h123, 8'h3C, "R6 late write via write enable", 1'b0, '0);

        // R6: late write ended by chip enable rising first
        write_ce(11'h124, 8'h22);
        addr = 11'h124; we_n = 1'b1; oe_n = 1'b1; ce_n = 1'b0;
        wait_n(ACC + 4);
        we_n = 1'b0;
        din = 8'h5A;
        wait_n(3);
        ce_n = 1'b1;
        wait_n(3);
        bus_idle(PRE + 8);
        read_at(11'h124, 8'h5A, "R6 late write via chip enable", 1'b0, '0);

        // R7: short write pulse, then a start while the cycle still runs
        write_ce(11'h200, 8'h77);
        check(err == 1'b0, "R7 error flag clear before test", int'(err), 0);
        addr = 11'h300; din = 8'h99; we_n = 1'b0; ce_n = 1'b0;
        wait_n(3);
        ce_n = 1'b1; we_n = 1'b1;
        wait_n(3);
        addr = 11'h200; din = 8'h66; we_n = 1'b0; ce_n = 1'b0;
        wait_n(4);
        bus_idle(PRE + ACC + 10);
        check(err == 1'b1, "R7 early start flagged", int'(err), 1);
        read_at(11'h300, 8'h99, "R5 short write stored", 1'b0, '0);
        read_at(11'h200, 8'h77, "R7 early start ignored", 1'b0, '0);

        // R9: reset clears the flag, keeps the array
        rst = 1'b1;
        wait_n(3);
        rst = 1'b0;
        wait_n(2);
        check(err == 1'b0, "R9 error flag after reset", int'(err), 0);
        check(den == 1'b0, "R9 drive enable after reset", int'(den), 0);
        read_at(11'h300, 8'h99, "R9 array kept over reset", 1'b0, '0);

        // R8: too short a precharge rejects the next start
        addr = 11'h010; din = 8'h42; we_n = 1'b0; oe_n = 1'b1; ce_n = 1'b0;
        wait_n(ACC + 4);
        ce_n = 1'b1; we_n = 1'b1;
        wait_n(2);
        din = 8'hBD; we_n = 1'b0; ce_n = 1'b0;
        wait_n(ACC + 4);
        bus_idle(PRE + 8);
        check(err == 1'b1, "R8 short precharge flagged", int'(err), 1);
        read_at(11'h010, 8'h42, "R8 rejected start wrote nothing", 1'b0, '0);
        check(err == 1'b1, "R8 flag stays set", int'(err), 1);

        check(exp_q.size() == 0, "R3 all expected reads seen", exp_q.size(), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule